// File: doc/BRIEF.md
# Extended capability list walker

This block walks a singly linked chain of extended capability headers held in a 4 KB configuration memory, which it reaches through a port one 32-bit word wide. Each header word carries a capability identifier, a version and the byte offset of the next header. The chain always starts at byte offset 256. A next offset of zero ends the chain.

Two commands arrive on a valid/ready command channel. A lookup returns the byte offset of the first header whose identifier equals the key, together with the offset of the header visited just before it. An insert writes a new header at a given offset and links it in. At offset 256 the new header takes over the next pointer of the header already there. At any other offset the block walks to the last header, points that header at the new one, and writes the new header as the new last entry. The block does not check whether the new capability overlaps existing ones. Completion is a one-cycle `done` pulse, with `err` and the two result offsets valid in that cycle.

Command handshake: the requester raises `cmd_valid` and holds every command field stable until it sees `cmd_ready` high at a clock edge. `cmd_ready` is high only while the block is idle. The results are not back-pressured. `done` lasts one cycle, and the result offsets then hold their values until the next command is accepted.

Top module: `extcap_list_walker`

## Requirements
- R1: After reset `cmd_ready` is 1, and `done`, `err`, `mem_rd` and `mem_wr` are 0.
- R2: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. Every header the block writes uses this layout.
- R3: A lookup whose key is nonzero and equals the identifier of a visited header returns that header's offset in `res_off`. `res_prev` holds the offset visited before it, or 0 when the match is at offset 256. `err` is 0.
- R4: When the word at offset 256 is zero, a lookup returns `res_off`=0, `res_prev`=0 and `err`=0.
- R5: When no header matches, a lookup returns `res_off`=0 and `res_prev`=offset of the last header. Key 0 never matches, so a lookup with key 0 returns the last header.
- R6: A next offset that is below 256, above 4088 or not a multiple of 4 ends the command with `err`=1 and no write.
- R7: When a command has read 1024 headers and the walk would still continue, it ends with `err`=1. This guards against looped chains.
- R8: An insert at offset 256 reads the old word there and writes one header with the old next field, the new version and the new identifier. It then reports `res_off`=256 and `res_prev`=0.
- R9: An insert at any other offset first rewrites the last header's next field to the new offset, keeping bits 19:0 of that header. It then writes the new header with a next field of 0 and reports `res_prev`=the last header's offset.
- R10: An insert is rejected with `err`=1, and with no memory access, unless all of these hold: the offset is a multiple of 4, the offset is at least 256, the size is at least 8, and offset+size is below 4096.
- R11: `cmd_ready` is low while a command runs. Read data is taken one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together. `done` is a single-cycle pulse.
- R12: An insert at an offset other than 256 into an empty chain (word at 256 equal to zero) ends with `err`=1 and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted at this edge |
| cmd_append | input | 1 | 1 = insert, 0 = lookup |
| cmd_id | input | 16 | Key for a lookup, identifier for an insert |
| cmd_ver | input | 4 | Version for an insert |
| cmd_off | input | 12 | Byte offset for an insert |
| cmd_size | input | 12 | Capability size in bytes for an insert |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| done | output | 1 | Command complete, one-cycle pulse |
| err | output | 1 | Command failed, valid with `done` |
| res_off | output | 12 | Found offset (lookup) or inserted offset |
| res_prev | output | 12 | Previous or last header offset |

## Verification
The assertions assume that the configuration memory returns the addressed word exactly one cycle after a read strobe. They also assume that nothing but this block writes the memory while a command runs. The bench meets both conditions with a behavioural memory that has a single-cycle read register and is only changed while the block is idle. Between commands the bench builds chains at aligned offsets with chosen next pointers. Deliberately bad pointers and looped chains are placed only where a check expects an error.

// File: rtl/extcap_pkg.sv
package extcap_pkg;
  localparam int unsigned ID_W  = 16;
  localparam int unsigned VER_W = 4;
  localparam int unsigned NXT_W = 12;

  typedef struct packed {
    logic [NXT_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } ext_hdr_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CMP,
    S_PATCH,
    S_WRITE,
    S_DONE
  } walk_state_t;
endpackage

// File: rtl/extcap_arg_check.sv
module extcap_arg_check #(
  parameter int unsigned AW       = 12,
  parameter int unsigned BASE     = 256,
  parameter int unsigned MIN_SIZE = 8
) (
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] size,
  output logic          ok
);
  logic [AW:0] span;

  always_comb begin
    span = {1'b0, off} + {1'b0, size};
    ok   = (off[1:0] == 2'b00) && (off >= AW'(BASE)) &&
           (size >= AW'(MIN_SIZE)) && !span[AW];
  end
endmodule

// File: rtl/extcap_next_check.sv
module extcap_next_check #(
  parameter int unsigned AW   = 12,
  parameter int unsigned BASE = 256
) (
  input  logic [AW-1:0] nxt,
  output logic          ok
);
  localparam logic [AW-1:0] TOP = AW'((1 << AW) - 8);

  always_comb begin
    ok = (nxt[1:0] == 2'b00) && (nxt >= AW'(BASE)) && (nxt <= TOP);
  end
endmodule

// File: rtl/extcap_step_ctr.sv
module extcap_step_ctr #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT - 1));

  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/extcap_list_walker.sv
module extcap_list_walker
  import extcap_pkg::*;
#(
  parameter int unsigned BASE       = 256,
  parameter int unsigned STEP_LIMIT = 1024,
  parameter int unsigned MIN_SIZE   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_append,
  input  logic [15:0]      cmd_id,
  input  logic [3:0]       cmd_ver,
  input  logic [11:0]      cmd_off,
  input  logic [11:0]      cmd_size,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [9:0]       mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic             err,
  output logic [11:0]      res_off,
  output logic [11:0]      res_prev
);
  localparam int unsigned AW = NXT_W;
  localparam int unsigned WA = AW - 2;
  localparam logic [AW-1:0] BASE_OFF = AW'(BASE);

  walk_state_t state;
  logic              op_app;
  logic [ID_W-1:0]   key;
  logic [VER_W-1:0]  ver;
  logic [AW-1:0]     noff, cur, prev, nnext;
  logic [19:0]       tail_lo;
  logic              err_q;
  logic [AW-1:0]     roff_q, rprev_q;

  logic     args_ok, nxt_ok, step_last;
  ext_hdr_t rh;
  logic     accept, in_cmp;

  assign rh        = ext_hdr_t'(mem_rdata);
  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign in_cmp    = (state == S_CMP);

  extcap_arg_check #(.AW(AW), .BASE(BASE), .MIN_SIZE(MIN_SIZE)) u_args (
    .off(cmd_off), .size(cmd_size), .ok(args_ok));

  extcap_next_check #(.AW(AW), .BASE(BASE)) u_nxt (
    .nxt(rh.nxt), .ok(nxt_ok));

  extcap_step_ctr #(.LIMIT(STEP_LIMIT)) u_steps (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(in_cmp),
    .at_limit(step_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_app  <= 1'b0;
      key     <= '0;
      ver     <= '0;
      noff    <= '0;
      cur     <= '0;
      prev    <= '0;
      nnext   <= '0;
      tail_lo <= '0;
      err_q   <= 1'b0;
      roff_q  <= '0;
      rprev_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_app  <= cmd_append;
          key     <= cmd_id;
          ver     <= cmd_ver;
          noff    <= cmd_off;
          cur     <= BASE_OFF;
          prev    <= '0;
          err_q   <= 1'b0;
          roff_q  <= '0;
          rprev_q <= '0;
          if (cmd_append && !args_ok) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            state <= S_READ;
          end
        end
        S_READ: state <= S_CMP;
        S_CMP: begin
          if (op_app && noff == BASE_OFF) begin
            nnext   <= rh.nxt;
            roff_q  <= noff;
            rprev_q <= '0;
            state   <= S_WRITE;
          end else if (cur == BASE_OFF && mem_rdata == '0) begin
            err_q <= op_app;
            state <= S_DONE;
          end else if (!op_app && key != '0 && rh.id == key) begin
            roff_q  <= cur;
            rprev_q <= prev;
            state   <= S_DONE;
          end else if (rh.nxt == '0) begin
            rprev_q <= cur;
            if (op_app) begin
              tail_lo <= mem_rdata[19:0];
              nnext   <= '0;
              roff_q  <= noff;
              state   <= S_PATCH;
            end else begin
              roff_q <= '0;
              state  <= S_DONE;
            end
          end else if (!nxt_ok || step_last) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            prev  <= cur;
            cur   <= rh.nxt;
            state <= S_READ;
          end
        end
        S_PATCH: state <= S_WRITE;
        S_WRITE: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (state == S_READ);
    mem_wr    = (state == S_PATCH) || (state == S_WRITE);
    mem_addr  = cur[AW-1:2];
    mem_wdata = '0;
    if (state == S_PATCH) begin
      mem_wdata = {noff, tail_lo};
    end else if (state == S_WRITE) begin
      mem_addr  = noff[AW-1:2];
      mem_wdata = ext_hdr_t'{nxt: nnext, ver: ver, id: key};
    end
  end

  assign done     = (state == S_DONE);
  assign err      = done && err_q;
  assign res_off  = roff_q;
  assign res_prev = rprev_q;

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || done) |-> !cmd_ready);
  p_start_at_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((mem_rd && mem_addr == WA'(BASE >> 2)) || done));
  p_bad_args_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_append && !args_ok) |=> (err && !mem_rd));
  p_patch_then_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PATCH) |=> (mem_wr && mem_wdata[31:20] == '0));
endmodule

// File: tb/extcap_list_walker_tb_top.sv
module extcap_list_walker_tb_top;
  localparam int LIMIT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_append = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_off = '0, cmd_size = '0;
  logic        cmd_ready, mem_rd, mem_wr, done, err;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [11:0] res_off, res_prev;

  logic [31:0] mem [0:1023];

  extcap_list_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_append(cmd_append), .cmd_id(cmd_id), .cmd_ver(cmd_ver),
    .cmd_off(cmd_off), .cmd_size(cmd_size), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .res_off(res_off), .res_prev(res_prev));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int nvec = 0, nfail = 0, cyc = 0;
  logic        r_err;
  logic [11:0] r_off, r_prev;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec = nvec + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] n, input logic [3:0] v, input logic [15:0] id);
    return {n, v, id};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  function automatic int mem_sum();
    int s = 0;
    for (int i = 0; i < 1024; i++) s = s + int'(mem[i]) * (i + 1);
    return s;
  endfunction

  // model of a lookup, derived from R3..R7
  task automatic model_find(input logic [15:0] key, output logic e,
                            output logic [11:0] off, output logic [11:0] pv);
    logic [11:0] cur, prv, n;
    logic [31:0] h;
    int steps;
    cur = 12'd256; prv = '0; e = 0; off = '0; pv = '0; steps = 0;
    if (mem[64] == '0) return;
    forever begin
      h = mem[cur >> 2];
      steps++;
      if (key != 0 && h[15:0] == key) begin off = cur; pv = prv; return; end
      n = h[31:20];
      if (n == 0) begin off = '0; pv = cur; return; end
      if (steps >= LIMIT || n < 256 || n > 4088 || n[1:0] != 0) begin e = 1; return; end
      prv = cur; cur = n;
    end
  endtask

  task automatic run_cmd(input bit app, input logic [15:0] id, input logic [3:0] v,
                         input logic [11:0] off, input logic [11:0] sz);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_append = app; cmd_id = id; cmd_ver = v;
    cmd_off = off; cmd_size = sz;
    @(negedge clk);
    cmd_valid = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    if (!done) chk(0, "R11 timeout", 32'(n), 32'd0);
    r_err = err; r_off = res_off; r_prev = res_prev;
  endtask

  initial begin
    logic        me;
    logic [11:0] moff, mprev;
    int          s0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk_eq("R1 ready", 32'(cmd_ready), 1);
    chk_eq("R1 done/err/rd/wr", {done, err, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk_eq("R1 idle after reset", {cmd_ready, done, mem_rd, mem_wr}, 4'b1000);

    // R4 empty chain
    run_cmd(0, 16'h0010, 0, 0, 0);
    chk_eq("R4 empty lookup", {r_err, r_off, r_prev}, 0);

    // R12 insert away from base into empty chain
    run_cmd(1, 16'h0007, 4'h2, 12'h300, 12'h10);
    chk_eq("R12 err", 32'(r_err), 1);
    chk_eq("R12 no write", mem[12'h300 >> 2] | mem[64], 0);

    // R8 insert at base, empty chain
    run_cmd(1, 16'h0001, 4'h1, 12'h100, 12'h40);
    chk_eq("R8 err", 32'(r_err), 0);
    chk_eq("R8 R2 header", mem[64], hdr(0, 4'h1, 16'h0001));
    chk_eq("R8 result", {r_off, r_prev}, {12'h100, 12'h000});

    // R9 insert at 0x200
    run_cmd(1, 16'h00A5, 4'h3, 12'h200, 12'h20);
    chk_eq("R9 err", 32'(r_err), 0);
    chk_eq("R9 R2 tail patched", mem[64], hdr(12'h200, 4'h1, 16'h0001));
    chk_eq("R9 R2 new header", mem[12'h200 >> 2], hdr(0, 4'h3, 16'h00A5));
    chk_eq("R9 prev", 32'(r_prev), 32'h100);

    // R3 matches
    run_cmd(0, 16'h00A5, 0, 0, 0);
    chk_eq("R3 match second", {r_err, r_off, r_prev}, {1'b0, 12'h200, 12'h100});
    run_cmd(0, 16'h0001, 0, 0, 0);
    chk_eq("R3 match at base", {r_err, r_off, r_prev}, {1'b0, 12'h100, 12'h000});

    // R5 key 0 and missing key
    run_cmd(0, 16'h0000, 0, 0, 0);
    chk_eq("R5 key zero tail", {r_err, r_off, r_prev}, {1'b0, 12'h000, 12'h200});
    run_cmd(0, 16'h7777, 0, 0, 0);
    chk_eq("R5 missing", {r_err, r_off, r_prev}, {1'b0, 12'h000, 12'h200});

    // R8 insert at base keeps old next
    run_cmd(1, 16'h0042, 4'h9, 12'h100, 12'h08);
    chk_eq("R8 inherits next", mem[64], hdr(12'h200, 4'h9, 16'h0042));

    // R10 argument rejection
    s0 = mem_sum();
    run_cmd(1, 16'h0003, 1, 12'h202, 12'h10);
    chk_eq("R10 misaligned", 32'(r_err), 1);
    run_cmd(1, 16'h0003, 1, 12'h080, 12'h10);
    chk_eq("R10 below base", 32'(r_err), 1);
    run_cmd(1, 16'h0003, 1, 12'h400, 12'h004);
    chk_eq("R10 small size", 32'(r_err), 1);
    run_cmd(1, 16'h0003, 1, 12'hFF0, 12'h010);
    chk_eq("R10 reaches 4096", 32'(r_err), 1);
    chk_eq("R10 memory unchanged", mem_sum(), s0);
    run_cmd(1, 16'h0003, 1, 12'hFF0, 12'h00F);
    chk_eq("R10 limit accepted", 32'(r_err), 0);
    chk_eq("R10 R9 appended", mem[12'hFF0 >> 2], hdr(0, 4'h1, 16'h0003));
    chk_eq("R9 old tail patched", mem[12'h200 >> 2], hdr(12'hFF0, 4'h3, 16'h00A5));

    // R6 bad pointers
    clear_mem(); mem[64] = hdr(12'h010, 1, 16'h0005);
    run_cmd(0, 16'h0009, 0, 0, 0);
    chk_eq("R6 below base", 32'(r_err), 1);
    mem[64] = hdr(12'hFFC, 1, 16'h0005);
    run_cmd(0, 16'h0009, 0, 0, 0);
    chk_eq("R6 above top", 32'(r_err), 1);
    mem[64] = hdr(12'h202, 1, 16'h0005);
    s0 = mem_sum();
    run_cmd(1, 16'h0009, 1, 12'h300, 12'h10);
    chk_eq("R6 misaligned next", 32'(r_err), 1);
    chk_eq("R6 no write", mem_sum(), s0);
    mem[64] = hdr(12'hFF8, 1, 16'h0005); mem[12'hFF8 >> 2] = hdr(0, 2, 16'h0006);
    run_cmd(0, 16'h0009, 0, 0, 0);
    chk_eq("R6 top boundary ok", {r_err, r_off, r_prev}, {1'b0, 12'h000, 12'hFF8});

    // R7 looped chain
    clear_mem(); mem[64] = hdr(12'h100, 1, 16'h0005);
    run_cmd(0, 16'h0009, 0, 0, 0);
    chk_eq("R7 loop guard", 32'(r_err), 1);

    // random chains
    for (int it = 0; it < 40; it++) begin
      int len;
      logic [11:0] offs [0:7];
      logic [11:0] pos, newo;
      logic [15:0] key;
      clear_mem();
      len = 1 + int'($urandom % 8);
      pos = 12'h100;
      for (int k = 0; k < len; k++) begin
        offs[k] = pos;
        pos = pos + 12'(8 * (1 + ($urandom % 8)));
      end
      for (int k = 0; k < len; k++)
        mem[offs[k] >> 2] = hdr((k == len - 1) ? 12'h0 : offs[k + 1],
                                4'($urandom), 16'(1 + ($urandom % 16)));
      key = ($urandom % 4 == 0) ? 16'h0 : 16'(1 + ($urandom % 20));
      model_find(key, me, moff, mprev);
      run_cmd(0, key, 0, 0, 0);
      chk_eq("R3 R5 random lookup", {r_err, r_off, r_prev}, {me, moff, mprev});
      model_find(16'h0, me, moff, mprev);
      newo = pos + 12'h10;
      run_cmd(1, 16'hBEEF, 4'hC, newo, 12'h08);
      chk_eq("R9 random insert", {r_err, r_prev}, {1'b0, mprev});
      chk_eq("R9 R2 random new", mem[newo >> 2], hdr(0, 4'hC, 16'hBEEF));
      chk_eq("R9 random patch", 32'(mem[mprev >> 2][31:20]), 32'(newo));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end
endmodule